// File: doc/BRIEF.md
# Fracturable Four-Input Lookup Logic Cell

This block is one programmable logic element. A sixteen-bit truth table is read by a four-level selection tree that can act as one four-input function or, when the split control is set, as two two-input functions sharing the two low inputs. A single carry link built from the two split results and the incoming carry produces a carry-out, and an output register captures either the table result or a raw general input, so the register can serve on its own.

All configuration (table bits, split control, and the two source selects) is presented as static parallel inputs held constant while the cell operates. The table result, the two split results and the carry-out are combinational; only the registered output has a clock edge in its path.

Top module: `frac_lut_cell`

## Requirements
- R1: `comb_o` equals `cfg_table[{t3, t2, gin[1], gin[0]}]`, where t3 is `gin[3] | cfg_split` and t2 is the selected source of table input 2 (bit 0 of the index is gin[0]).
- R2: With `cfg_split` = 1, table input 3 is held at 1, so `gin[3]` has no effect on `comb_o`.
- R3: `half_o[0]` equals `cfg_table[8 + {gin[1],gin[0]}]` and `half_o[1]` equals `cfg_table[12 + {gin[1],gin[0]}]`, independent of `gin[3:2]`, `carry_i` and every control bit.
- R4: Table input 2 takes `gin[2]` when `cfg_in2_sel` = 0 and `carry_i` when `cfg_in2_sel` = 1.
- R5: `carry_o` equals `carry_i` when `half_o[0]` = 1, and equals `half_o[1]` when `half_o[0]` = 0.
- R6: On a rising clock edge with `rst` = 0, `reg_o` loads `comb_o` when `cfg_ff_sel` = 0 and `gin[3]` when `cfg_ff_sel` = 1.
- R7: `rst` is synchronous and active high; at a rising edge with `rst` = 1, `reg_o` becomes 0 whatever the data path holds.
- R8: `comb_o`, `half_o` and `carry_o` respond to input changes within the same cycle, with no clock edge in their path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| gin | input | 4 | General logic inputs |
| carry_i | input | 1 | Carry from the neighbouring cell |
| cfg_table | input | 16 | Truth table bits |
| cfg_split | input | 1 | 1: two split functions, top table input forced high; 0: whole function |
| cfg_in2_sel | input | 1 | Source of table input 2: 0 gin[2], 1 carry_i |
| cfg_ff_sel | input | 1 | Register data source: 0 table result, 1 gin[3] |
| comb_o | output | 1 | Unregistered table result |
| half_o | output | 2 | The two split results from the upper table halves |
| reg_o | output | 1 | Registered output |
| carry_o | output | 1 | Carry to the next cell |

## Verification
The bench targets the forced top input in split mode: a cell that failed to OR the split bit in would read the lower table half and return a value that changes with gin[3]. It exercises both sources of table input 2 with tables whose halves differ, so a swapped or missing carry selection shows up as a wrong result, and it drives both polarities of the propagate term so an inverted carry link gives the wrong carry-out. The register is checked for both data sources and for reset overriding a data value of 1, which catches a swapped register mux or a reset that loses priority.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;
  localparam int LUT_INPUTS = 4;
  localparam int SPLIT_TAP  = 2;

  typedef enum logic {
    IN2_FROM_GIN   = 1'b0,
    IN2_FROM_CARRY = 1'b1
  } in2_src_e;

  typedef enum logic {
    FF_FROM_LUT = 1'b0,
    FF_FROM_GIN = 1'b1
  } ff_src_e;
endpackage

// File: rtl/lut_mux_tree.sv
module lut_mux_tree #(
  parameter int K       = 4,
  parameter int TAP_LVL = 2,
  parameter int CFG_W   = 1 << K
) (
  input  logic [CFG_W-1:0] table_bits,
  input  logic [K-1:0]     sel,
  output logic             full_o,
  output logic [1:0]       tap_o
);
  localparam int TAP_N = CFG_W >> TAP_LVL;

  for (genvar l = 0; l <= K; l++) begin : g_lvl
    localparam int N = CFG_W >> l;
    logic [N-1:0] v;
    if (l == 0) begin : g_root
      assign v = table_bits;
    end else begin : g_node
      for (genvar j = 0; j < N; j++) begin : g_mux
        assign v[j] = sel[l-1] ? g_lvl[l-1].v[2*j+1] : g_lvl[l-1].v[2*j];
      end
    end
  end

  assign full_o = g_lvl[K].v[0];
  assign tap_o  = g_lvl[TAP_LVL].v[TAP_N-1 -: 2];
endmodule

// File: rtl/lut_carry_link.sv
module lut_carry_link (
  input  logic prop,
  input  logic gen_d,
  input  logic cin,
  output logic cout
);
  always_comb begin
    if (prop) cout = cin;
    else      cout = gen_d;
  end
endmodule

// File: rtl/lut_out_reg.sv
module lut_out_reg
  import frac_lut_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ff_src_e src_sel,
  input  logic    lut_d,
  input  logic    byp_d,
  output logic    q
);
  logic d_sel;
  assign d_sel = (src_sel == FF_FROM_GIN) ? byp_d : lut_d;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_sel;
  end

  AST_REG_CLEAR: assert property (@(posedge clk) rst |=> (q == 1'b0)); // R7
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == ($past(src_sel) == FF_FROM_GIN ? $past(byp_d) : $past(lut_d)))); // R6
endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
  import frac_lut_pkg::*;
#(
  parameter int K       = LUT_INPUTS,
  parameter int TAP_LVL = SPLIT_TAP,
  parameter int CFG_W   = 1 << K
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [K-1:0]     gin,
  input  logic             carry_i,
  input  logic [CFG_W-1:0] cfg_table,
  input  logic             cfg_split,
  input  logic             cfg_in2_sel,
  input  logic             cfg_ff_sel,
  output logic             comb_o,
  output logic [1:0]       half_o,
  output logic             reg_o,
  output logic             carry_o
);
  localparam int IN2_IDX = 2;
  localparam int TOP_IDX = K - 1;

  in2_src_e   in2_src;
  ff_src_e    ff_src;
  logic [K-1:0] lut_sel;

  assign in2_src = in2_src_e'(cfg_in2_sel);
  assign ff_src  = ff_src_e'(cfg_ff_sel);

  always_comb begin
    lut_sel          = gin;
    lut_sel[IN2_IDX] = (in2_src == IN2_FROM_CARRY) ? carry_i : gin[IN2_IDX];
    lut_sel[TOP_IDX] = gin[TOP_IDX] | cfg_split;
  end

  lut_mux_tree #(.K(K), .TAP_LVL(TAP_LVL), .CFG_W(CFG_W)) u_tree (
    .table_bits (cfg_table),
    .sel        (lut_sel),
    .full_o     (comb_o),
    .tap_o      (half_o)
  );

  lut_carry_link u_carry (
    .prop  (half_o[0]),
    .gen_d (half_o[1]),
    .cin   (carry_i),
    .cout  (carry_o)
  );

  lut_out_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .src_sel (ff_src),
    .lut_d   (comb_o),
    .byp_d   (gin[TOP_IDX]),
    .q       (reg_o)
  );

  AST_SPLIT_RESULT: assert property (@(posedge clk) disable iff (rst)
    cfg_split |-> (comb_o == (lut_sel[IN2_IDX] ? half_o[1] : half_o[0]))); // R2
  AST_CARRY_PASS: assert property (@(posedge clk) disable iff (rst)
    half_o[0] |-> (carry_o == carry_i)); // R5
  AST_CARRY_GEN: assert property (@(posedge clk) disable iff (rst)
    !half_o[0] |-> (carry_o == half_o[1])); // R5
  AST_IN2_CARRY: assert property (@(posedge clk) disable iff (rst)
    (cfg_in2_sel && !cfg_split && !gin[TOP_IDX]) |->
      (comb_o == cfg_table[{1'b0, carry_i, gin[1:0]}])); // R4
endmodule

// File: tb/sim_frac_lut_cell.sv
module sim_frac_lut_cell;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  gin;
  logic        carry_i;
  logic [15:0] cfg_table;
  logic        cfg_split, cfg_in2_sel, cfg_ff_sel;
  logic        comb_o, reg_o, carry_o;
  logic [1:0]  half_o;

  int errs = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_lut_cell u0 (
    .clk(clk), .rst(rst), .gin(gin), .carry_i(carry_i), .cfg_table(cfg_table),
    .cfg_split(cfg_split), .cfg_in2_sel(cfg_in2_sel), .cfg_ff_sel(cfg_ff_sel),
    .comb_o(comb_o), .half_o(half_o), .reg_o(reg_o), .carry_o(carry_o)
  );

  // stimulus: {table, split, in2_sel, gin, carry_in}
  localparam logic [22:0] VEC [NVEC] = '{
    {16'hAAAA, 1'b0, 1'b0, 4'b0001, 1'b0},
    {16'h00FF, 1'b1, 1'b0, 4'b0000, 1'b0},
    {16'h00FF, 1'b0, 1'b0, 4'b0000, 1'b0},
    {16'h0F0F, 1'b0, 1'b1, 4'b0000, 1'b1},
    {16'h0F0F, 1'b0, 1'b0, 4'b0000, 1'b1},
    {16'h1200, 1'b1, 1'b0, 4'b0001, 1'b1},
    {16'h1200, 1'b1, 1'b1, 4'b1010, 1'b0},
    {16'h8000, 1'b0, 1'b0, 4'b1111, 1'b1}
  };

  // reference: {comb, carry, half1, half0}
  function automatic logic [3:0] model(logic [15:0] t, logic sp, logic s2,
                                       logic [3:0] g, logic ci);
    logic t3, t2, h0, h1, cm, cy;
    t3 = g[3] | sp;
    t2 = s2 ? ci : g[2];
    cm = t[{t3, t2, g[1], g[0]}];
    h0 = t[{2'b10, g[1], g[0]}];
    h1 = t[{2'b11, g[1], g[0]}];
    cy = h0 ? ci : h1;
    return {cm, cy, h1, h0};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_comb(string req);
    logic [3:0] e;
    e = model(cfg_table, cfg_split, cfg_in2_sel, gin, carry_i);
    check(req, {comb_o, carry_o, half_o}, e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic exp_q;
    rst = 1'b1; gin = 4'hF; carry_i = 1'b0; cfg_table = 16'hFFFF;
    cfg_split = 1'b0; cfg_in2_sel = 1'b0; cfg_ff_sel = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 reset state", {3'b0, reg_o}, 4'b0000);
    rst = 1'b0;

    // table walk: R1 R3 R4 R5 R8, same-cycle sampling
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {cfg_table, cfg_split, cfg_in2_sel, gin, carry_i} = VEC[i];
      #1 check_comb("R1/R3/R4/R5/R8 table");
    end

    // R2: gin[3] ignored in split mode
    @(negedge clk);
    cfg_table = 16'h00FF; cfg_split = 1'b1; cfg_in2_sel = 1'b0;
    gin = 4'b0000; carry_i = 1'b0;
    #1 check("R2 split gin3=0", {3'b0, comb_o}, 4'b0000);
    gin = 4'b1000;
    #1 check("R2 split gin3=1", {3'b0, comb_o}, 4'b0000);

    // R4: carry as table input 2
    cfg_table = 16'h0F0F; cfg_split = 1'b0; gin = 4'b0000; carry_i = 1'b1;
    cfg_in2_sel = 1'b1;
    #1 check("R4 in2 from carry", {3'b0, comb_o}, 4'b0000);
    cfg_in2_sel = 1'b0;
    #1 check("R4 in2 from gin", {3'b0, comb_o}, 4'b0001);

    // R5: propagate both polarities
    cfg_table = 16'h1100; gin = 4'b0000; carry_i = 1'b0;
    #1 check("R5 propagate", {3'b0, carry_o}, 4'b0000);
    cfg_table = 16'h1000;
    #1 check("R5 generate", {3'b0, carry_o}, 4'b0001);

    // R6: register sources, random traffic
    for (int i = 0; i < 200; i++) begin
      logic [3:0] e;
      @(negedge clk);
      cfg_table   = 16'($urandom);
      cfg_split   = 1'($urandom);
      cfg_in2_sel = 1'($urandom);
      cfg_ff_sel  = 1'($urandom);
      gin         = 4'($urandom);
      carry_i     = 1'($urandom);
      #1 check_comb("R1/R3/R5 random");
      e = model(cfg_table, cfg_split, cfg_in2_sel, gin, carry_i);
      exp_q = cfg_ff_sel ? gin[3] : e[3];
      @(negedge clk);
      check("R6 register load", {3'b0, reg_o}, {3'b0, exp_q});
    end

    // R7: reset beats data 1
    @(negedge clk);
    cfg_ff_sel = 1'b1; gin = 4'b1000;
    @(negedge clk);
    check("R6 bypass load", {3'b0, reg_o}, 4'b0001);
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset priority", {3'b0, reg_o}, 4'b0000);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule